// File: doc/BRIEF.md
# Polynomial Sequence Self-Test Checker

This block judges whether a short capture from a random source, taken while that source ran in its deterministic health-check mode, agrees with a known 64-bit polynomial sequence. Software or a capture engine fills an eight-word buffer through a simple write port and then pulses start. The checker walks the reference sequence from a fixed seed, one position per clock, and counts how many captured words match.

The buffer's first word is never compared, because the first word out of the source after a mode change is not trusted. Each clock, all seven remaining slots are compared against the current reference value at once, and the number of equal slots is added to a running total. The test passes when that total reaches the goal. It fails when the iteration cap is used up first.

The capture that feeds this check is expected to be taken with:
- the shift register feedback enabled,
- every noise source turned off,
- analog mux select 2,
- a wait field of 38857.

The checker itself only sees the captured words.

Top module: `lfsr_selftest_checker`

## Requirements
- R1: After reset, busy, pass and fail are all 0 and every buffer slot holds zero.
- R2: When load_en is high and busy is low, load_data is written into the slot selected by load_idx (0 to 7). A load presented while busy is high is ignored and leaves the buffer unchanged.
- R3: A start pulse while idle raises busy on the next cycle and clears pass and fail. It also resets the reference value to 0xB8820C7BD387E32C, the match total to 0 and the iteration count to 0.
- R4: Between iterations the reference value moves one position. It shifts left by one with a zero shifted in, and if the bit shifted out was 1 the result is XORed with 0x231DCEE91262B8A3.
- R5: In each busy cycle, slots 1 to 7 are compared with the current reference value and each equal slot adds one to the match total. Slot 0 never contributes.
- R6: If the total including the current iteration's matches is 6 or more, the run ends on that clock edge: busy falls and pass rises. The test is made before the value advances.
- R7: If 40000 iterations finish without reaching the goal, busy falls and fail rises. When the goal is first reached on the 40000th iteration, pass is reported and not fail.
- R8: A start pulse while busy is ignored. The running iteration, total and reference value go on unchanged.
- R9: Pass and fail are never high together and are both low while busy. Once set, the result holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Write one buffer slot |
| load_idx | input | 3 | Slot written by load_en |
| load_data | input | 64 | Captured word to store |
| start | input | 1 | Begin a check when idle |
| busy | output | 1 | A check is in progress |
| pass | output | 1 | Last check reached the match goal |
| fail | output | 1 | Last check hit the iteration cap |

## Verification
Reaching the match goal and exhausting the iteration cap can both happen on the same clock, the 40000th iteration. The bench provokes this by filling six compared slots with the reference value at position 39999, computed in the bench by stepping the polynomial. Across the run, the behavioural model and the explicit check both expect pass alone, raised exactly 40000 busy cycles after start, with fail staying low. A second long run stops one match short of the goal and tries to load the missing word while the check is busy. Only fail at the cap is accepted there, which shows that the load was dropped.

// File: rtl/lfsr_selftest_checker.sv
module lfsr_selftest_checker #(
  parameter int W = 64,
  parameter int DEPTH = 8,
  parameter logic [63:0] SEED = 64'hB8820C7BD387E32C,
  parameter logic [63:0] POLY = 64'h231DCEE91262B8A3,
  parameter int GOAL = 6,
  parameter int LIMIT = 40000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [$clog2(DEPTH)-1:0] load_idx,
  input  logic [W-1:0]             load_data,
  input  logic                     start,
  output logic                     busy,
  output logic                     pass,
  output logic                     fail
);
  localparam int IW = $clog2(LIMIT + 1);
  localparam int TW = $clog2(GOAL + DEPTH) + 1;

  logic [W-1:0]     slot [DEPTH];
  logic [W-1:0]     val;
  logic [W-1:0]     val_next;
  logic [IW-1:0]    iter;
  logic [TW-1:0]    total;
  logic [TW-1:0]    hits;
  logic [TW-1:0]    total_next;
  logic [DEPTH-1:0] hit;
  logic             goal_hit;
  logic             last_iter;

  assign hit[0] = 1'b0;
  for (genvar i = 1; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = (slot[i] == val);
  end

  always_comb begin
    hits = '0;
    for (int k = 0; k < DEPTH; k++) hits = hits + TW'(hit[k]);
  end

  assign total_next = total + hits;
  assign goal_hit   = total_next >= TW'(GOAL);
  assign last_iter  = iter == IW'(LIMIT - 1);
  assign val_next   = {val[W-2:0], 1'b0} ^ (val[W-1] ? POLY[W-1:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) slot[k] <= '0;
      busy  <= 1'b0;
      pass  <= 1'b0;
      fail  <= 1'b0;
      val   <= SEED[W-1:0];
      iter  <= '0;
      total <= '0;
    end else begin
      if (load_en && !busy) slot[load_idx] <= load_data;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          pass  <= 1'b0;
          fail  <= 1'b0;
          val   <= SEED[W-1:0];
          iter  <= '0;
          total <= '0;
        end
      end else if (goal_hit) begin
        busy <= 1'b0;
        pass <= 1'b1;
      end else if (last_iter) begin
        busy <= 1'b0;
        fail <= 1'b1;
      end else begin
        val   <= val_next;
        iter  <= iter + 1'b1;
        total <= total_next;
      end
    end
  end

  assert_one_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));
  assert_no_result_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!pass && !fail));
  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(pass) && $stable(fail)));
  assert_start_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && iter == '0 && total == '0 && val == SEED[W-1:0]));
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !goal_hit && !last_iter) |=>
      (val == ({$past(val[W-2:0]), 1'b0} ^ ($past(val[W-1]) ? POLY[W-1:0] : '0))));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !goal_hit && !last_iter) |=> (busy && iter == $past(iter) + 1'b1));
  assert_total_below_goal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (total < TW'(GOAL)));
  assert_end_has_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (pass ^ fail));
endmodule

// File: tb/lfsr_selftest_checker_test.sv
module lfsr_selftest_checker_test;
  localparam logic [63:0] SEED = 64'hB8820C7BD387E32C;
  localparam logic [63:0] POLY = 64'h231DCEE91262B8A3;

  logic clk = 0, rst_n = 0, load_en = 0, start = 0;
  logic [2:0] load_idx = 0;
  logic [63:0] load_data = 0;
  logic busy, pass, fail;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lfsr_selftest_checker uut (.clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
    .load_data(load_data), .start(start), .busy(busy), .pass(pass), .fail(fail));

  function automatic logic [63:0] seq(int n);
    logic [63:0] v = SEED;
    for (int i = 0; i < n; i++) v = {v[62:0], 1'b0} ^ (v[63] ? POLY : 64'h0);
    return v;
  endfunction

  logic [63:0] m_slot [8];
  logic [63:0] m_val;
  bit m_busy, m_pass, m_fail;
  int m_iter, m_total;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) m_slot[k] = 0;
      m_busy = 0; m_pass = 0; m_fail = 0; m_val = SEED; m_iter = 0; m_total = 0;
    end else begin
      automatic bit was_busy = m_busy;
      automatic int h = 0;
      if (was_busy) begin
        for (int k = 1; k < 8; k++) if (m_slot[k] == m_val) h++;
        if (m_total + h >= 6) begin m_busy = 0; m_pass = 1; end
        else if (m_iter == 39999) begin m_busy = 0; m_fail = 1; end
        else begin
          m_val = {m_val[62:0], 1'b0} ^ (m_val[63] ? POLY : 64'h0);
          m_iter++; m_total += h;
        end
      end else if (start) begin
        m_busy = 1; m_pass = 0; m_fail = 0; m_val = SEED; m_iter = 0; m_total = 0;
      end
      if (load_en && !was_busy) m_slot[load_idx] = load_data;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if ({busy, pass, fail} !== {m_busy, m_pass, m_fail}) begin
      errors++;
      $display("FAIL R6 cycle compare: busy/pass/fail actual %b%b%b expected %b%b%b",
               busy, pass, fail, m_busy, m_pass, m_fail);
    end
  end

  task automatic check(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic load(int idx, logic [63:0] d);
    @(negedge clk);
    load_en = 1; load_idx = 3'(idx); load_data = d;
    @(negedge clk);
    load_en = 0;
  endtask

  task automatic fill(logic [63:0] w [8]);
    for (int k = 0; k < 8; k++) load(k, w[k]);
  endtask

  task automatic run(bit exp_pass, int exp_iter, string tag,
                     int inj_at, bit inj_start, bit inj_load, int inj_idx, logic [63:0] inj_data);
    int cnt = 0;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy && !pass && !fail, "R3 start clears result", {busy, pass, fail}, 3'b100);
    while (busy && cnt < 50000) begin
      cnt++;
      if (cnt == inj_at) begin
        start = inj_start; load_en = inj_load; load_idx = 3'(inj_idx); load_data = inj_data;
      end else begin
        start = 0; load_en = 0;
      end
      @(negedge clk);
    end
    start = 0; load_en = 0;
    check(cnt == exp_iter + 1, {tag, " busy cycles"}, cnt, exp_iter + 1);
    check(pass == exp_pass && fail == !exp_pass, {tag, " result"}, {pass, fail}, {exp_pass, !exp_pass});
  endtask

  initial begin
    logic [63:0] b [8];
    logic [63:0] s0 = seq(0), s3 = seq(3), s5 = seq(5), s10 = seq(10), sl = seq(39999);
    repeat (3) @(negedge clk);
    check(!busy && !pass && !fail, "R1 reset outputs", {busy, pass, fail}, 0);
    rst_n = 1;
    @(negedge clk);

    b = '{64'h0, s0, s0, s0, s0, s0, s0, s0};
    fill(b);
    run(1, 0, "R2 R5 all match first step", 0, 0, 0, 0, 0);

    b = '{64'h0, s0, s0, s0, s5, s5, s5, 64'h0};
    fill(b);
    run(1, 5, "R4 R8 split matches, start while busy", 2, 1, 0, 0, 0);

    b = '{s0, s0, s0, s0, s0, s0, s10, 64'h0};
    fill(b);
    run(1, 10, "R5 slot 0 excluded", 0, 0, 0, 0, 0);

    b = '{64'h0, s0, s0, s0, s0, s0, 64'h0, 64'h0};
    fill(b);
    run(0, 39999, "R2 R7 load while busy dropped, cap reached", 1, 0, 1, 6, s3);
    repeat (5) @(negedge clk);
    check(fail && !pass && !busy, "R9 result held", {busy, pass, fail}, 3'b001);

    b = '{64'h0, sl, sl, sl, sl, sl, sl, 64'h0};
    fill(b);
    run(1, 39999, "R7 goal on last iteration wins", 0, 0, 0, 0, 0);
    check(!fail, "R9 exclusive after coincidence", fail, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule